// File: doc/BRIEF.md
# Spare Row and Column Remap Decoder

This block sits between the address of a memory access and the array's line decoders. It keeps a small table of repair entries for word lines and another for bit lines. Each entry holds the address of one defective line and a valid bit. On every access the row field and the column field are compared with all valid entries of their own table at the same time. A hit disables the main decoder for that field and selects the matching spare line. A miss leaves the main decoder enabled and selects no spare. Row and column repair are separate, so a single access may hit a spare row, a spare column, both or neither.

Entries are loaded through a configuration port that behaves like a bank of fuses. An entry can be written once, and only the block's reset makes it writable again. A build parameter picks one of two spare modes. In the global mode any spare can repair any line. In the scoped mode each spare serves one fixed region of its address space, and a write that names an address outside that region is refused. A second parameter adds an output register stage.

Top module: `spare_remap`

## Requirements
- R1: While `rstN` is low, and after it rises with no writes yet, every entry is invalid: `rowHit`, `colHit`, both conflict flags and `cfgErr` are 0, both spare selects are all zero, and both main enables are 1.
- R2: When a valid row entry k stores `rowAddr`, `rowHit` is 1, `rowMainEn` is 0 and `rowSpareSel` has only bit k set. Bit k of a select vector always stands for entry k.
- R3: Column matching works the same way on `colAddr`, `colHit`, `colMainEn` and `colSpareSel`, and it does not depend on the row side. A column entry stores the low COL_W bits of `cfgAddr`.
- R4: When no valid entry of a table matches, that side's hit and conflict flags are 0, its select is zero and its main enable is 1. `rowAddrOut` and `colAddrOut` always equal `rowAddr` and `colAddr`.
- R5: In global mode (SCOPED=0), any row entry accepts any row address and any column entry accepts any column address.
- R6: A write to an entry whose valid bit is already set changes nothing, and `cfgErr` is 1 in the cycle after the write.
- R7: In scoped mode (SCOPED=1), row entry k accepts only addresses whose top ROW_REG_W bits equal k mod 2^ROW_REG_W. Column entry k accepts only addresses whose top COL_REG_W column bits equal k mod 2^COL_REG_W. Any other address is refused: `cfgErr` is 1 in the next cycle and the entry stays invalid.
- R8: When two or more valid entries of a table match, the lowest index wins the select and that side's conflict flag is 1.
- R9: A write whose `cfgIdx` is at or above the entry count of the targeted table (`cfgCol`=0 rows, 1 columns) changes nothing and raises `cfgErr` in the next cycle.
- R10: An accepted write sets its entry valid from the following cycle on and leaves `cfgErr` at 0. When no write is made, `cfgErr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; clears every entry |
| cfgWr | input | 1 | Repair-entry write strobe |
| cfgCol | input | 1 | Target table: 0 row, 1 column |
| cfgIdx | input | IDX_W | Entry index to write |
| cfgAddr | input | ADDR_W | Defective line address to store |
| cfgErr | output | 1 | Write refused (registered, one cycle after the write) |
| rowAddr | input | ROW_W | Row field of the access |
| colAddr | input | COL_W | Column field of the access |
| rowAddrOut | output | ROW_W | Row address passed to the main decoder |
| colAddrOut | output | COL_W | Column address passed to the main decoder |
| rowMainEn | output | 1 | Main row decoder enable |
| colMainEn | output | 1 | Main column decoder enable |
| rowSpareSel | output | N_ROW | One-hot spare word-line select |
| colSpareSel | output | N_COL | One-hot spare bit-line select |
| rowHit | output | 1 | Row access was steered to a spare |
| colHit | output | 1 | Column access was steered to a spare |
| rowConflict | output | 1 | More than one valid row entry matched |
| colConflict | output | 1 | More than one valid column entry matched |

## Verification
A global-mode and a scoped-mode instance get the same stimulus, so one write sequence exercises both acceptance rules. A region check with the wrong bit slice would let the scoped instance take out-of-region addresses, or refuse in-region ones, and its hits would no longer match the model. Writes to entries that are already valid go after the one-time rule: a design that overwrote them would move the spare to the new address and lose the old hit. Duplicate entries exercise the priority rule, where a highest-index pick or a missing conflict flag shows up at once. Writes with an index past the end of a table check that the bound is enforced, and would catch a design that wrapped the index onto a real entry.

// File: rtl/spare_remap_pkg.sv
package spare_remap_pkg;

  // Upper bound on spares per table; the strobe struct is sized to it.
  localparam int MAX_SPARES = 16;

  typedef struct packed {
    logic [MAX_SPARES-1:0] rowLoad;  // burn row entry k
    logic [MAX_SPARES-1:0] colLoad;  // burn column entry k
    logic                  reject;   // write refused
  } cfgStrobe_t;

endpackage

// File: rtl/remap_bank.sv
// One table of repair entries: storage, parallel compare, lowest-index pick.
module remap_bank #(
  parameter int N = 4,
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] load,
  input  logic [W-1:0] loadAddr,
  input  logic [W-1:0] addr,
  output logic [N-1:0] valid,
  output logic [N-1:0] sel,
  output logic         hit,
  output logic         conflict
);

  logic [W-1:0] entry [N];
  logic [N-1:0] match;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valid <= '0;
      for (int k = 0; k < N; k++) entry[k] <= '0;
    end else begin
      for (int k = 0; k < N; k++) begin
        if (load[k]) begin
          valid[k] <= 1'b1;
          entry[k] <= loadAddr;
        end
      end
    end
  end

  generate
    for (genvar k = 0; k < N; k++) begin : gCmp
      assign match[k] = valid[k] && (entry[k] == addr);
    end
  endgenerate

  // Isolate the lowest set bit; any bit left over means a second match.
  assign sel      = match & (~match + 1'b1);
  assign conflict = |(match & (match - 1'b1));
  assign hit      = |match;

endmodule

// File: rtl/remap_ctrl.sv
// Decides whether a configuration write is accepted and which entry it burns.
module remap_ctrl
  import spare_remap_pkg::*;
#(
  parameter int N_ROW     = 4,
  parameter int N_COL     = 6,
  parameter int ROW_W     = 10,
  parameter int COL_W     = 8,
  parameter int ROW_REG_W = 4,
  parameter int COL_REG_W = 1,
  parameter bit SCOPED    = 1'b0,
  parameter int IDX_W     = 3,
  parameter int ADDR_W    = 10
) (
  input  logic              cfgWr,
  input  logic              cfgCol,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [N_ROW-1:0]  rowValid,
  input  logic [N_COL-1:0]  colValid,
  output cfgStrobe_t        strobe
);

  logic rowInRange, colInRange, rowTaken, colTaken, rowRegionOk, colRegionOk;

  always_comb begin
    rowInRange = 1'b0;
    rowTaken   = 1'b0;
    for (int k = 0; k < N_ROW; k++) begin
      if (cfgIdx == IDX_W'(k)) begin
        rowInRange = 1'b1;
        rowTaken   = rowValid[k];
      end
    end
    colInRange = 1'b0;
    colTaken   = 1'b0;
    for (int k = 0; k < N_COL; k++) begin
      if (cfgIdx == IDX_W'(k)) begin
        colInRange = 1'b1;
        colTaken   = colValid[k];
      end
    end
  end

  generate
    if (SCOPED) begin : gScoped
      assign rowRegionOk = cfgAddr[ROW_W-1 -: ROW_REG_W] == ROW_REG_W'(cfgIdx);
      assign colRegionOk = cfgAddr[COL_W-1 -: COL_REG_W] == COL_REG_W'(cfgIdx);
    end else begin : gGlobal
      assign rowRegionOk = 1'b1;
      assign colRegionOk = 1'b1;
    end
  endgenerate

  always_comb begin
    strobe = '0;
    if (cfgWr) begin
      if (cfgCol) begin
        if (!colInRange || colTaken || !colRegionOk) strobe.reject = 1'b1;
        else strobe.colLoad[cfgIdx] = 1'b1;
      end else begin
        if (!rowInRange || rowTaken || !rowRegionOk) strobe.reject = 1'b1;
        else strobe.rowLoad[cfgIdx] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/remap_dp.sv
// Datapath: the two entry tables, the error register and the output stage.
module remap_dp
  import spare_remap_pkg::*;
#(
  parameter int N_ROW   = 4,
  parameter int N_COL   = 6,
  parameter int ROW_W   = 10,
  parameter int COL_W   = 8,
  parameter int ADDR_W  = 10,
  parameter bit REG_OUT = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strobe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [ROW_W-1:0]  rowAddr,
  input  logic [COL_W-1:0]  colAddr,
  output logic [N_ROW-1:0]  rowValid,
  output logic [N_COL-1:0]  colValid,
  output logic              cfgErr,
  output logic [ROW_W-1:0]  rowAddrOut,
  output logic [COL_W-1:0]  colAddrOut,
  output logic              rowMainEn,
  output logic              colMainEn,
  output logic [N_ROW-1:0]  rowSpareSel,
  output logic [N_COL-1:0]  colSpareSel,
  output logic              rowHit,
  output logic              colHit,
  output logic              rowConflict,
  output logic              colConflict
);

  logic [N_ROW-1:0] rSel;
  logic [N_COL-1:0] cSel;
  logic             rHit, cHit, rCf, cCf;

  remap_bank #(.N(N_ROW), .W(ROW_W)) rowBank_i (
    .clk(clk), .rstN(rstN), .load(strobe.rowLoad[N_ROW-1:0]),
    .loadAddr(cfgAddr[ROW_W-1:0]), .addr(rowAddr), .valid(rowValid),
    .sel(rSel), .hit(rHit), .conflict(rCf));

  remap_bank #(.N(N_COL), .W(COL_W)) colBank_i (
    .clk(clk), .rstN(rstN), .load(strobe.colLoad[N_COL-1:0]),
    .loadAddr(cfgAddr[COL_W-1:0]), .addr(colAddr), .valid(colValid),
    .sel(cSel), .hit(cHit), .conflict(cCf));

  generate
    if (N_ROW < MAX_SPARES) begin : gRowSpareBits
      logic unusedRowLoad;
      assign unusedRowLoad = ^strobe.rowLoad[MAX_SPARES-1:N_ROW];
    end
    if (N_COL < MAX_SPARES) begin : gColSpareBits
      logic unusedColLoad;
      assign unusedColLoad = ^strobe.colLoad[MAX_SPARES-1:N_COL];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgErr <= 1'b0;
    else       cfgErr <= strobe.reject;
  end

  generate
    if (REG_OUT) begin : gRegOut
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          rowAddrOut  <= '0;
          colAddrOut  <= '0;
          rowMainEn   <= 1'b1;
          colMainEn   <= 1'b1;
          rowSpareSel <= '0;
          colSpareSel <= '0;
          rowHit      <= 1'b0;
          colHit      <= 1'b0;
          rowConflict <= 1'b0;
          colConflict <= 1'b0;
        end else begin
          rowAddrOut  <= rowAddr;
          colAddrOut  <= colAddr;
          rowMainEn   <= !rHit;
          colMainEn   <= !cHit;
          rowSpareSel <= rSel;
          colSpareSel <= cSel;
          rowHit      <= rHit;
          colHit      <= cHit;
          rowConflict <= rCf;
          colConflict <= cCf;
        end
      end
    end else begin : gCombOut
      assign rowAddrOut  = rowAddr;
      assign colAddrOut  = colAddr;
      assign rowMainEn   = !rHit;
      assign colMainEn   = !cHit;
      assign rowSpareSel = rSel;
      assign colSpareSel = cSel;
      assign rowHit      = rHit;
      assign colHit      = cHit;
      assign rowConflict = rCf;
      assign colConflict = cCf;
    end
  endgenerate

endmodule

// File: rtl/spare_remap.sv
module spare_remap
  import spare_remap_pkg::*;
#(
  parameter int N_ROW     = 4,
  parameter int N_COL     = 6,
  parameter int ROW_W     = 10,
  parameter int COL_W     = 8,
  parameter int ROW_REG_W = 4,
  parameter int COL_REG_W = 1,
  parameter bit SCOPED    = 1'b0,
  parameter bit REG_OUT   = 1'b0,
  localparam int MAX_N    = (N_ROW > N_COL) ? N_ROW : N_COL,
  localparam int IDX_W    = (MAX_N > 2) ? $clog2(MAX_N) : 1,
  localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic              cfgCol,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [ADDR_W-1:0] cfgAddr,
  output logic              cfgErr,
  input  logic [ROW_W-1:0]  rowAddr,
  input  logic [COL_W-1:0]  colAddr,
  output logic [ROW_W-1:0]  rowAddrOut,
  output logic [COL_W-1:0]  colAddrOut,
  output logic              rowMainEn,
  output logic              colMainEn,
  output logic [N_ROW-1:0]  rowSpareSel,
  output logic [N_COL-1:0]  colSpareSel,
  output logic              rowHit,
  output logic              colHit,
  output logic              rowConflict,
  output logic              colConflict
);

  cfgStrobe_t       strobe;
  logic [N_ROW-1:0] rowValid;
  logic [N_COL-1:0] colValid;

  remap_ctrl #(
    .N_ROW(N_ROW), .N_COL(N_COL), .ROW_W(ROW_W), .COL_W(COL_W),
    .ROW_REG_W(ROW_REG_W), .COL_REG_W(COL_REG_W), .SCOPED(SCOPED),
    .IDX_W(IDX_W), .ADDR_W(ADDR_W)
  ) ctrl_i (
    .cfgWr(cfgWr), .cfgCol(cfgCol), .cfgIdx(cfgIdx), .cfgAddr(cfgAddr),
    .rowValid(rowValid), .colValid(colValid), .strobe(strobe));

  remap_dp #(
    .N_ROW(N_ROW), .N_COL(N_COL), .ROW_W(ROW_W), .COL_W(COL_W),
    .ADDR_W(ADDR_W), .REG_OUT(REG_OUT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgAddr(cfgAddr),
    .rowAddr(rowAddr), .colAddr(colAddr), .rowValid(rowValid),
    .colValid(colValid), .cfgErr(cfgErr), .rowAddrOut(rowAddrOut),
    .colAddrOut(colAddrOut), .rowMainEn(rowMainEn), .colMainEn(colMainEn),
    .rowSpareSel(rowSpareSel), .colSpareSel(colSpareSel), .rowHit(rowHit),
    .colHit(colHit), .rowConflict(rowConflict), .colConflict(colConflict));

endmodule

// File: rtl/spare_remap_chk.sv
module spare_remap_chk #(
  parameter int N_ROW   = 4,
  parameter int N_COL   = 6,
  parameter int ROW_W   = 10,
  parameter int COL_W   = 8,
  parameter bit REG_OUT = 1'b0
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWr,
  input logic             cfgErr,
  input logic [ROW_W-1:0] rowAddr,
  input logic [COL_W-1:0] colAddr,
  input logic [N_ROW-1:0] rowSpareSel,
  input logic [N_COL-1:0] colSpareSel,
  input logic             rowHit,
  input logic             colHit,
  input logic             rowConflict,
  input logic             colConflict
);

  AST_ROW_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN) $onehot0(rowSpareSel)); // R2
  AST_COL_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN) $onehot0(colSpareSel)); // R3
  AST_ROW_CONFLICT_HIT: assert property (@(posedge clk) disable iff (!rstN) rowConflict |-> rowHit); // R8
  AST_COL_CONFLICT_HIT: assert property (@(posedge clk) disable iff (!rstN) colConflict |-> colHit); // R8
  AST_ERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN) cfgErr |-> $past(cfgWr)); // R6

  generate
    if (!REG_OUT) begin : gCombChecks
      AST_ROW_SEL_HELD: assert property (@(posedge clk) disable iff (!rstN)
        (!$past(cfgWr) && $stable(rowAddr)) |-> $stable(rowSpareSel)); // R10
      AST_COL_SEL_HELD: assert property (@(posedge clk) disable iff (!rstN)
        (!$past(cfgWr) && $stable(colAddr)) |-> $stable(colSpareSel)); // R10
    end
  endgenerate

endmodule

bind spare_remap spare_remap_chk #(
  .N_ROW(N_ROW), .N_COL(N_COL), .ROW_W(ROW_W), .COL_W(COL_W), .REG_OUT(REG_OUT)
) chk_i (
  .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgErr(cfgErr),
  .rowAddr(rowAddr), .colAddr(colAddr), .rowSpareSel(rowSpareSel),
  .colSpareSel(colSpareSel), .rowHit(rowHit), .colHit(colHit),
  .rowConflict(rowConflict), .colConflict(colConflict));

// File: tb/spare_remap_tb_top.sv
module spare_remap_tb_top;

  localparam int NR = 4, NC = 6, RW = 10, CW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWr = 1'b0, cfgCol = 1'b0;
  logic [2:0]  cfgIdx = '0;
  logic [9:0]  cfgAddr = '0;
  logic [RW-1:0] rowAddr = '0;
  logic [CW-1:0] colAddr = '0;

  // outputs: index 0 global instance, index 1 scoped instance
  logic          oErr [2];
  logic [RW-1:0] oRowOut [2];
  logic [CW-1:0] oColOut [2];
  logic          oRowMain [2], oColMain [2], oRowHit [2], oColHit [2];
  logic          oRowCf [2], oColCf [2];
  logic [NR-1:0] oRowSel [2];
  logic [NC-1:0] oColSel [2];

  always #10 clk = ~clk;  // 50 MHz

  spare_remap #(.SCOPED(1'b0)) dut_i (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgCol(cfgCol), .cfgIdx(cfgIdx),
    .cfgAddr(cfgAddr), .cfgErr(oErr[0]), .rowAddr(rowAddr), .colAddr(colAddr),
    .rowAddrOut(oRowOut[0]), .colAddrOut(oColOut[0]), .rowMainEn(oRowMain[0]),
    .colMainEn(oColMain[0]), .rowSpareSel(oRowSel[0]), .colSpareSel(oColSel[0]),
    .rowHit(oRowHit[0]), .colHit(oColHit[0]), .rowConflict(oRowCf[0]),
    .colConflict(oColCf[0]));

  spare_remap #(.SCOPED(1'b1)) dutScp (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgCol(cfgCol), .cfgIdx(cfgIdx),
    .cfgAddr(cfgAddr), .cfgErr(oErr[1]), .rowAddr(rowAddr), .colAddr(colAddr),
    .rowAddrOut(oRowOut[1]), .colAddrOut(oColOut[1]), .rowMainEn(oRowMain[1]),
    .colMainEn(oColMain[1]), .rowSpareSel(oRowSel[1]), .colSpareSel(oColSel[1]),
    .rowHit(oRowHit[1]), .colHit(oColHit[1]), .rowConflict(oRowCf[1]),
    .colConflict(oColCf[1]));

  // ---------------- behavioural reference ----------------
  int  rEnt [2][NR];
  bit  rVal [2][NR];
  int  cEnt [2][NC];
  bit  cVal [2][NC];
  bit  mErr [2];
  int  rowList[$];
  int  colList[$];

  int  nRun = 0, nFail = 0;
  bit  finished = 0;
  string phase = "R1";

  always @(posedge clk or negedge rstN) begin
    for (int m = 0; m < 2; m++) begin
      if (!rstN) begin
        mErr[m] = 0;
        for (int k = 0; k < NR; k++) begin rVal[m][k] = 0; rEnt[m][k] = 0; end
        for (int k = 0; k < NC; k++) begin cVal[m][k] = 0; cEnt[m][k] = 0; end
      end else begin
        int idx;
        idx = int'(cfgIdx);
        mErr[m] = 0;
        if (cfgWr) begin
          if (cfgCol) begin
            if (idx >= NC || cVal[m][idx]) mErr[m] = 1;
            else if (m == 1 && ((int'(cfgAddr) >> 7) & 1) != (idx % 2)) mErr[m] = 1;
            else begin cVal[m][idx] = 1; cEnt[m][idx] = int'(cfgAddr) & 8'hFF; end
          end else begin
            if (idx >= NR || rVal[m][idx]) mErr[m] = 1;
            else if (m == 1 && ((int'(cfgAddr) >> 6) & 15) != (idx % 16)) mErr[m] = 1;
            else begin rVal[m][idx] = 1; rEnt[m][idx] = int'(cfgAddr); end
          end
        end
      end
    end
  end

  task automatic chk(string field, int m, int act, int exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s inst%0d actual=%0h expected=%0h at %0t", phase, field, m, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    for (int m = 0; m < 2; m++) begin
      int rFirst, rCnt, cFirst, cCnt;
      rFirst = -1; rCnt = 0; cFirst = -1; cCnt = 0;
      for (int k = 0; k < NR; k++)
        if (rVal[m][k] && rEnt[m][k] == int'(rowAddr)) begin
          if (rFirst < 0) rFirst = k;
          rCnt++;
        end
      for (int k = 0; k < NC; k++)
        if (cVal[m][k] && cEnt[m][k] == int'(colAddr)) begin
          if (cFirst < 0) cFirst = k;
          cCnt++;
        end
      chk("rowHit",      m, int'(oRowHit[m]),  int'(rCnt > 0));
      chk("rowMainEn",   m, int'(oRowMain[m]), int'(rCnt == 0));
      chk("rowSpareSel", m, int'(oRowSel[m]),  (rFirst < 0) ? 0 : (1 << rFirst));
      chk("rowConflict", m, int'(oRowCf[m]),   int'(rCnt > 1));
      chk("rowAddrOut",  m, int'(oRowOut[m]),  int'(rowAddr));
      chk("colHit",      m, int'(oColHit[m]),  int'(cCnt > 0));
      chk("colMainEn",   m, int'(oColMain[m]), int'(cCnt == 0));
      chk("colSpareSel", m, int'(oColSel[m]),  (cFirst < 0) ? 0 : (1 << cFirst));
      chk("colConflict", m, int'(oColCf[m]),   int'(cCnt > 1));
      chk("colAddrOut",  m, int'(oColOut[m]),  int'(colAddr));
      chk("cfgErr",      m, int'(oErr[m]),     int'(mErr[m]));
    end
  endtask

  // Hold the current inputs across one rising edge, then compare.
  task automatic tick();
    @(posedge clk);
    #5;
    checkAll();
  endtask

  task automatic access(int ra, int ca);
    cfgWr = 0; rowAddr = RW'(ra); colAddr = CW'(ca);
    tick();
  endtask

  task automatic burn(bit col, int idx, int addr);
    cfgWr = 1; cfgCol = col; cfgIdx = 3'(idx); cfgAddr = 10'(addr);
    if (col) colList.push_back(addr & 8'hFF); else rowList.push_back(addr & 10'h3FF);
    tick();
    cfgWr = 0;
  endtask

  task automatic doReset();
    rstN = 0; cfgWr = 0;
    rowList.delete(); colList.delete();
    tick(); tick();
    rstN = 1;
    tick();
  endtask

  initial begin
    // R1: reset state
    phase = "R1";
    rowAddr = 10'h000; colAddr = 8'h00;
    tick(); tick();
    rowAddr = 10'h2A5;
    tick();
    rstN = 1;
    tick();

    // R5 / R7: the same writes, accepted globally, partly refused when scoped
    phase = "R5";
    burn(0, 0, 10'h3C1);       // region 15: scoped entry 0 refuses
    burn(0, 1, 10'h055);       // region 1: both accept
    burn(1, 0, 8'h12);         // column region 0: both accept
    burn(1, 3, 8'h34);         // column region 0 at odd entry: scoped refuses
    phase = "R7";
    burn(0, 0, 10'h02E);       // retry entry 0 in region 0 (global: already valid)
    burn(0, 2, 10'h0B0);       // region 2 entry 2: accepted
    burn(0, 3, 10'h100);       // region 4 at entry 3: scoped refuses
    burn(1, 5, 8'h9A);         // column region 1 at odd entry: accepted
    burn(1, 4, 8'hF0);         // column region 1 at even entry: scoped refuses

    // R2 / R3 / R4: accesses to repaired and healthy lines
    phase = "R2";
    access(10'h3C1, 8'h00);
    access(10'h055, 8'h01);
    access(10'h02E, 8'h02);
    access(10'h0B0, 8'h03);
    phase = "R3";
    access(10'h001, 8'h12);
    access(10'h002, 8'h34);
    access(10'h055, 8'h9A);
    phase = "R4";
    access(10'h3FF, 8'hFF);
    access(10'h0B1, 8'h13);

    // R6: a second write to a valid entry is refused and changes nothing
    phase = "R6";
    burn(0, 1, 10'h077);
    access(10'h055, 8'h00);
    access(10'h077, 8'h00);
    burn(1, 0, 8'h66);
    access(10'h000, 8'h12);
    access(10'h000, 8'h66);

    // R9: index beyond the table
    phase = "R9";
    burn(0, 4, 10'h000);
    burn(0, 7, 10'h1C7);
    burn(1, 6, 8'h00);
    burn(1, 7, 8'h80);
    access(10'h1C7, 8'h80);

    // R8: duplicate entries, lowest index wins
    phase = "R8";
    doReset();
    burn(0, 1, 10'h050);
    burn(0, 3, 10'h050);
    burn(0, 0, 10'h010);
    burn(1, 2, 8'h44);
    burn(1, 4, 8'h44);
    burn(1, 1, 8'hC4);
    burn(1, 5, 8'hC4);
    access(10'h050, 8'h44);
    access(10'h010, 8'hC4);
    access(10'h011, 8'h45);

    // R10: accepted writes clear the error flag
    phase = "R10";
    burn(0, 2, 10'h0A0);
    burn(0, 2, 10'h0A0);
    burn(1, 3, 8'h01);
    access(10'h0A0, 8'h01);

    // Random fault sets, accesses biased toward repaired lines
    for (int round = 0; round < 24; round++) begin
      phase = (round % 2 == 0) ? "R2" : "R3";
      doReset();
      for (int k = 0; k < 9; k++) begin
        int idx, a;
        bit col;
        col = $urandom_range(0, 1) == 1;
        idx = col ? $urandom_range(0, 7) : $urandom_range(0, 5);
        if ($urandom_range(0, 2) != 0)
          a = col ? (((idx % 2) << 7) | $urandom_range(0, 127))
                  : (((idx % 16) << 6) | $urandom_range(0, 63));
        else if (col && colList.size() > 0 && $urandom_range(0, 1) == 1)
          a = colList[$urandom_range(0, colList.size() - 1)];
        else
          a = col ? $urandom_range(0, 255) : $urandom_range(0, 1023);
        burn(col, idx, a);
      end
      for (int n = 0; n < 120; n++) begin
        int ra, ca;
        ra = (rowList.size() > 0 && $urandom_range(0, 1) == 1)
             ? rowList[$urandom_range(0, rowList.size() - 1)] : $urandom_range(0, 1023);
        ca = (colList.size() > 0 && $urandom_range(0, 1) == 1)
             ? colList[$urandom_range(0, colList.size() - 1)] : $urandom_range(0, 255);
        if (n % 40 == 0) phase = "R4";
        access(ra, ca);
      end
    end

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      nRun++;
      nFail++;
      $display("FAIL watchdog expired phase %s actual=running expected=done", phase);
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule